// File: doc/BRIEF.md
# Dual-Port Memory with Mailbox Interrupts

This block is a synchronous two-port memory of 4096 words by 18 bits. Each side, called A and B, has its own chip select, output enable, write enable, 12-bit address, write data and read data. Either side can read or write any word at any time. Read data is registered and appears one clock after the address.

The two highest addresses can also serve as mailboxes between the sides. Address 0xFFE is the inbox of side A and 0xFFF is the inbox of side B. When side B writes 0xFFE, side A's active-low interrupt asserts. The interrupt stays asserted until side A selects 0xFFE with its output enable asserted. Traffic toward side B works the same way through 0xFFF. The mailbox words hold ordinary 18-bit user data, so the receiver reads the message and clears its interrupt with the same access.

The mailbox function is switched on by a mode input. While the mode input is low, both top words are plain storage and both interrupts stay deasserted.

Top module: `dpram_mailbox`

## Requirements
- R1: A write (cs=1, we=1) stores wdata at addr. A read (cs=1, oe=1, we=0) presents the stored word on rdata after the next rising clock edge.
- R2: With mbox_en=1, a write by side B to address 0xFFE drives a_irq_n low after the next rising edge.
- R3: With mbox_en=1, side A clears its interrupt (a_irq_n high after the next edge) by an access to 0xFFE with a_cs=1 and a_oe=1. The level of a_we does not matter.
- R4: With mbox_en=1, a write by side A to 0xFFF drives b_irq_n low. Side B clears it by an access to 0xFFF with b_cs=1 and b_oe=1, whatever the level of b_we.
- R5: The words at 0xFFE and 0xFFF store and return 18-bit user data like every other word, so a clearing read returns the message.
- R6: While mbox_en=0, both interrupt outputs are high after the next edge, and accesses to 0xFFE and 0xFFF never assert them.
- R7: A side with cs=0 performs no access. It writes nothing, clears no interrupt and leaves its rdata unchanged. An interrupt with neither a set nor a clear keeps its level.
- R8: If one side writes the other side's inbox in the same cycle as the other side clears it, the set wins and the interrupt stays low.
- R9: A read and a write to the same address by the two sides in the same cycle return the old data to the reader.
- R10: After reset, a_irq_n and b_irq_n are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mbox_en | input | 1 | 1 enables the mailbox interrupts |
| a_cs | input | 1 | Side A chip select |
| a_oe | input | 1 | Side A output enable |
| a_we | input | 1 | Side A write enable |
| a_addr | input | 12 | Side A word address |
| a_wdata | input | 18 | Side A write data |
| a_rdata | output | 18 | Side A registered read data |
| a_irq_n | output | 1 | Side A interrupt, active low |
| b_cs | input | 1 | Side B chip select |
| b_oe | input | 1 | Side B output enable |
| b_we | input | 1 | Side B write enable |
| b_addr | input | 12 | Side B word address |
| b_wdata | input | 18 | Side B write data |
| b_rdata | output | 18 | Side B registered read data |
| b_irq_n | output | 1 | Side B interrupt, active low |

## Verification
The assertions assume that the two sides never write the same word in the same cycle. That case belongs to access arbitration, which this block does not provide. The random stimulus keeps within this assumption: whenever both sides would write one address, side B's write enable is dropped. Addresses are drawn mostly from the two mailbox words and a few low words, so that sets, clears, collisions and same-address read/write pairs occur often. Directed cases then force the set-versus-clear race and the disabled mode.

// File: rtl/dpram_mailbox_pkg.sv
package dpram_mailbox_pkg;

    typedef enum logic {SIDE_A = 1'b0, SIDE_B = 1'b1} side_e;

    // Inbox of a side: A owns the second-highest word, B the highest.
    function automatic int unsigned inbox_index(int unsigned depth, side_e s);
        return (s == SIDE_A) ? depth - 2 : depth - 1;
    endfunction

endpackage

// File: rtl/dpram_core.sv
module dpram_core #(
    parameter int AW = 12,
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_rd,
    input  logic          a_wr,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_rd,
    input  logic          b_wr,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] b;
    } rd_t;

    logic [DW-1:0] mem [DEPTH];
    rd_t rd_d, rd_q;

    // Array writes; the read registers sample the array before the update.
    always_ff @(posedge clk) begin
        if (a_wr) mem[a_addr] <= a_wdata;
        if (b_wr) mem[b_addr] <= b_wdata;
    end

    always_comb begin
        rd_d = rd_q;
        if (a_rd) rd_d.a = mem[a_addr];
        if (b_rd) rd_d.b = mem[b_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign a_rdata = rd_q.a;
    assign b_rdata = rd_q.b;
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic set,
    input  logic clr,
    output logic irq_n
);
    typedef struct packed {
        logic flag;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en)      st_d.flag = 1'b0;
        else if (set) st_d.flag = 1'b1;   // set wins over a same-cycle clear
        else if (clr) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_n = ~st_q.flag;
endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox
    import dpram_mailbox_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mbox_en,
    input  logic          a_cs,
    input  logic          a_oe,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    output logic          a_irq_n,
    input  logic          b_cs,
    input  logic          b_oe,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          b_irq_n
);
    localparam int DEPTH = 1 << AW;

    logic [1:0]    cs_v, oe_v, we_v, irq_n_v;
    logic [AW-1:0] addr_v [2];

    assign cs_v      = {b_cs, a_cs};
    assign oe_v      = {b_oe, a_oe};
    assign we_v      = {b_we, a_we};
    assign addr_v[0] = a_addr;
    assign addr_v[1] = b_addr;

    dpram_core #(.AW(AW), .DW(DW)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_rd    (a_cs & a_oe & ~a_we),
        .a_wr    (a_cs & a_we),
        .a_addr  (a_addr),
        .a_wdata (a_wdata),
        .a_rdata (a_rdata),
        .b_rd    (b_cs & b_oe & ~b_we),
        .b_wr    (b_cs & b_we),
        .b_addr  (b_addr),
        .b_wdata (b_wdata),
        .b_rdata (b_rdata)
    );

    // One interrupt per side: set by the opposite side writing this inbox,
    // cleared by this side selecting its inbox with output enable.
    for (genvar g = 0; g < 2; g++) begin : g_side
        localparam int OTHER = 1 - g;
        localparam logic [AW-1:0] INBOX =
            AW'(inbox_index(DEPTH, (g == 0) ? SIDE_A : SIDE_B));
        logic set_w, clr_w;

        assign set_w = cs_v[OTHER] & we_v[OTHER] & (addr_v[OTHER] == INBOX);
        assign clr_w = cs_v[g] & oe_v[g] & (addr_v[g] == INBOX);

        mbox_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (mbox_en),
            .set   (set_w),
            .clr   (clr_w),
            .irq_n (irq_n_v[g])
        );
    end

    assign a_irq_n = irq_n_v[0];
    assign b_irq_n = irq_n_v[1];
endmodule

// File: rtl/dpram_mailbox_chk.sv
module dpram_mailbox_chk #(
    parameter int AW = 12,
    parameter int DW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mbox_en,
    input logic          a_cs,
    input logic          a_oe,
    input logic          a_we,
    input logic [AW-1:0] a_addr,
    input logic [DW-1:0] a_rdata,
    input logic          a_irq_n,
    input logic          b_cs,
    input logic          b_oe,
    input logic          b_we,
    input logic [AW-1:0] b_addr,
    input logic [DW-1:0] b_rdata,
    input logic          b_irq_n
);
    localparam logic [AW-1:0] BOX_A = {{(AW-1){1'b1}}, 1'b0};
    localparam logic [AW-1:0] BOX_B = {AW{1'b1}};

    logic hit_set_a, hit_clr_a, hit_set_b, hit_clr_b;
    assign hit_set_a = b_cs && b_we && (b_addr == BOX_A);
    assign hit_clr_a = a_cs && a_oe && (a_addr == BOX_A);
    assign hit_set_b = a_cs && a_we && (a_addr == BOX_B);
    assign hit_clr_b = b_cs && b_oe && (b_addr == BOX_B);

    AST_SET_A: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_en && hit_set_a) |=> !a_irq_n);                       // R2
    AST_CLR_A: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_en && hit_clr_a && !hit_set_a) |=> a_irq_n);          // R3
    AST_SET_B: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_en && hit_set_b) |=> !b_irq_n);                       // R4
    AST_CLR_B: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_en && hit_clr_b && !hit_set_b) |=> b_irq_n);          // R4
    AST_MODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !mbox_en |=> (a_irq_n && b_irq_n));                         // R6
    AST_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_en && !hit_set_a && !hit_clr_a) |=> $stable(a_irq_n)); // R7
    AST_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_en && !hit_set_b && !hit_clr_b) |=> $stable(b_irq_n)); // R7
    AST_RDATA_A: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_cs && a_oe && !a_we) |=> $stable(a_rdata));             // R7
    AST_RDATA_B: assert property (@(posedge clk) disable iff (!rst_n)
        !(b_cs && b_oe && !b_we) |=> $stable(b_rdata));             // R7
endmodule

bind dpram_mailbox dpram_mailbox_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mbox_en(mbox_en),
    .a_cs(a_cs), .a_oe(a_oe), .a_we(a_we), .a_addr(a_addr),
    .a_rdata(a_rdata), .a_irq_n(a_irq_n),
    .b_cs(b_cs), .b_oe(b_oe), .b_we(b_we), .b_addr(b_addr),
    .b_rdata(b_rdata), .b_irq_n(b_irq_n)
);

// File: tb/dpram_mailbox_tb.sv
module dpram_mailbox_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int DW = 18;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] BOX_A = 12'hFFE;
    localparam logic [AW-1:0] BOX_B = 12'hFFF;

    logic clk = 0, rst_n = 0, mbox_en = 0;
    logic a_cs = 0, a_oe = 0, a_we = 0, b_cs = 0, b_oe = 0, b_we = 0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0, a_rdata, b_rdata;
    logic a_irq_n, b_irq_n;

    int checks = 0, failures = 0;

    logic [DW-1:0] mdl_mem [DEPTH];
    bit            mdl_vld [DEPTH];
    bit            flag_a = 0, flag_b = 0;
    logic [DW-1:0] exp_ra, exp_rb;
    bit            vld_ra = 0, vld_rb = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpram_mailbox #(.AW(AW), .DW(DW)) u_dut (.*);

    function automatic bit next_flag(bit en, bit cur, bit set, bit clr);
        if (!en) return 1'b0;
        if (set) return 1'b1;
        if (clr) return 1'b0;
        return cur;
    endfunction

    task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive_a(bit cs, bit oe, bit we, logic [AW-1:0] ad, logic [DW-1:0] d);
        a_cs = cs; a_oe = oe; a_we = we; a_addr = ad; a_wdata = d;
    endtask

    task automatic drive_b(bit cs, bit oe, bit we, logic [AW-1:0] ad, logic [DW-1:0] d);
        b_cs = cs; b_oe = oe; b_we = we; b_addr = ad; b_wdata = d;
    endtask

    task automatic idle();
        drive_a(0, 0, 0, '0, '0);
        drive_b(0, 0, 0, '0, '0);
    endtask

    // Apply the current inputs for one clock, update the model, check outputs.
    task automatic step(string tag);
        bit sa, ca, sb, cb;
        sa = b_cs && b_we && b_addr == BOX_A;
        ca = a_cs && a_oe && a_addr == BOX_A;
        sb = a_cs && a_we && a_addr == BOX_B;
        cb = b_cs && b_oe && b_addr == BOX_B;
        flag_a = next_flag(mbox_en, flag_a, sa, ca);
        flag_b = next_flag(mbox_en, flag_b, sb, cb);
        if (a_cs && a_oe && !a_we) begin exp_ra = mdl_mem[a_addr]; vld_ra = mdl_vld[a_addr]; end
        if (b_cs && b_oe && !b_we) begin exp_rb = mdl_mem[b_addr]; vld_rb = mdl_vld[b_addr]; end
        if (a_cs && a_we) begin mdl_mem[a_addr] = a_wdata; mdl_vld[a_addr] = 1; end
        if (b_cs && b_we) begin mdl_mem[b_addr] = b_wdata; mdl_vld[b_addr] = 1; end
        @(posedge clk);
        @(negedge clk);
        check(tag, "a_irq_n", DW'(a_irq_n), DW'(!flag_a));
        check(tag, "b_irq_n", DW'(b_irq_n), DW'(!flag_b));
        if (vld_ra) check(tag, "a_rdata", a_rdata, exp_ra);
        if (vld_rb) check(tag, "b_rdata", b_rdata, exp_rb);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd7013));
        repeat (3) @(negedge clk);
        check("R10", "a_irq_n reset", DW'(a_irq_n), DW'(1'b1));
        check("R10", "b_irq_n reset", DW'(b_irq_n), DW'(1'b1));
        rst_n = 1;
        mbox_en = 1;
        @(negedge clk);

        // R1: plain write then read
        drive_a(1, 0, 1, 12'h005, 18'h2A5A5); step("R1");
        idle(); drive_b(1, 1, 0, 12'h005, '0); step("R1");

        // R2 and R5: B posts a message to A's inbox
        idle(); drive_b(1, 0, 1, BOX_A, 18'h3C0DE); step("R2");
        idle(); step("R7");
        // R7: deselected A at its inbox with oe clears nothing
        drive_a(0, 1, 0, BOX_A, '0); step("R7");
        // R5 and R3: A reads the message and clears
        drive_a(1, 1, 0, BOX_A, '0); step("R5");
        // R3: clear with we high (also a write), after a new post
        idle(); drive_b(1, 0, 1, BOX_A, 18'h11111); step("R2");
        drive_b(0, 0, 0, '0, '0); drive_a(1, 1, 1, BOX_A, 18'h22222); step("R3");

        // R4: A posts to B, B clears
        idle(); drive_a(1, 0, 1, BOX_B, 18'h0BEEF); step("R4");
        idle(); drive_b(1, 1, 0, BOX_B, '0); step("R4");

        // R8 and R9: B posts while A clears and reads the old word
        idle(); drive_b(1, 0, 1, BOX_A, 18'h1F00F); drive_a(1, 1, 0, BOX_A, '0); step("R8");
        idle(); drive_a(1, 1, 0, BOX_A, '0); step("R9");

        // R7: deselected write does nothing
        drive_a(0, 0, 1, 12'h005, 18'h00000); step("R7");
        drive_a(1, 1, 0, 12'h005, '0); step("R7");

        // R6: disable drops a raised flag and blocks new sets
        idle(); drive_b(1, 0, 1, BOX_A, 18'h0AAAA); step("R2");
        idle(); mbox_en = 0; step("R6");
        drive_a(1, 0, 1, BOX_B, 18'h15555); step("R6");
        idle(); drive_b(1, 1, 0, BOX_B, '0); step("R6");
        mbox_en = 1;

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [AW-1:0] aa, ba;
            int r;
            r  = $urandom % 4;
            aa = (r == 0) ? BOX_A : (r == 1) ? BOX_B : AW'($urandom % 8);
            r  = $urandom % 4;
            ba = (r == 0) ? BOX_A : (r == 1) ? BOX_B : AW'($urandom % 8);
            drive_a($urandom % 4 != 0, $urandom % 2, $urandom % 2, aa, DW'($urandom));
            drive_b($urandom % 4 != 0, $urandom % 2, $urandom % 2, ba, DW'($urandom));
            if (a_cs && a_we && b_cs && b_we && a_addr == b_addr) b_we = 0;
            mbox_en = ($urandom % 16) != 0;
            step("R1");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule